// File: doc/BRIEF.md
# Dual-Mode Per-Processor Counter Array

This block holds one counter channel for each processor of a small multiprocessor cluster. Each channel works in one of two personalities, and one bit per processor in a shared mode register picks it. In counter mode the channel counts scaled ticks up to a programmable limit. It then wraps to zero, latches a reached flag and raises its own interrupt line. In user mode the same three register slots give access to a 63-bit timestamp. Software can load it, start it and stop it, and it never interrupts.

The count advances by one unit on each `tick` strobe. The unit is bit `FRAC` of the visible value, and the bits below it always read as zero. Software reaches the registers through a plain word bus. `bus_chan` 0 selects the system slot, which holds only the mode register at word 4. `bus_chan` k (1..NCPU) selects processor k-1, with word 0 as high/limit, word 1 as low/count and word 3 as run status. Read data is combinational. Read side effects (limit acknowledge, high-word shadow capture) take effect at the clock edge of the read cycle.

When a mode bit flips, the channel runs a fixed sequence. It stops, clears its count, reached flag and interrupt, and then comes up in the new personality. A channel entering user mode starts out stopped. A channel returning to counter mode always runs, with its limit cleared to free-run.

Top module: `pcnt_array`

## Requirements
- R1: After reset the mode register is 0, every channel is in counter mode with count, limit and reached cleared, its interrupt is low and its status word 3 reads 1.
- R2: A write to channel 0 word 4 loads the mode register, where bit i set places processor i in user mode. Bits at or above NCPU are ignored and read back as zero.
- R3: In counter mode a write to word 0 loads the limit from wdata[30:9], clears count, reached and interrupt. A read of word 0 returns the limit in bits 30:9 and clears reached and the interrupt.
- R4: In counter mode each tick adds one to the count. Word 1 reads {reached, count in bits 30:9}. With limit L nonzero, the tick at count L-1 wraps the count to 0 and sets reached and the interrupt. With limit 0 the counter free-runs with no interrupt.
- R5: In counter mode writes to word 1 and word 3 have no effect, and word 3 reads 1.
- R6: Switching a channel to user mode drops its interrupt, stops it, and clears its count and reached flag.
- R7: Switching a channel back to counter mode clears count, reached and limit and leaves it running as a counter.
- R8: In user mode word 0 reads {reached, count bits 62:32} and word 1 reads count bits 31:0, with bits 8:0 zero.
- R9: In user mode writing word 0 loads count bits 62:32 from wdata[30:0], and writing word 1 loads count bits 31:9 from wdata[31:9]. Both writes clear reached.
- R10: In user mode writing word 3 bit 0 starts (1) or stops (0) the timer, and word 3 reads the running state. The count moves by 0x200 per tick only while running.
- R11: In user mode a tick at the all-ones count wraps to zero and sets reached. The interrupt of a user-mode channel is never asserted.
- R12: In user mode a word 1 read captures the current word 0 value. The next word 0 read returns that capture, and later word 0 reads are live again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count strobe, one unit per asserted cycle |
| bus_chan | input | 3 | Slot select: 0 system, k processor k-1 |
| bus_word | input | 3 | Word index inside the slot |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (enables read side effects) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | NCPU | Per-processor interrupt lines |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle and that `bus_chan` stays within 0..NCPU while a strobe is high. They also assume that a mode write and a channel access never share a cycle, which the single shared select already guarantees. The bench drives one operation per cycle from tasks that raise exactly one strobe and pick only legal slots. Its random phase keeps limits small so that wraps and interrupts happen often. It also loads user counts near the all-ones value often enough to reach the 63-bit wrap.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
   // word index of a register inside a slot
   typedef enum logic [2:0] {
      OFF_HI   = 3'd0,
      OFF_LO   = 3'd1,
      OFF_RSVD = 3'd2,
      OFF_RUN  = 3'd3,
      OFF_MODE = 3'd4
   } pcnt_off_e;

   localparam int unsigned WORD_W  = 32;
   localparam int unsigned FULL_W  = 63;
endpackage

// File: rtl/pcnt_modereg.sv
module pcnt_modereg #(
   parameter int unsigned NCPU = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [NCPU-1:0] wdata,
   output logic [NCPU-1:0] mode_q,
   output logic [NCPU-1:0] to_user,
   output logic [NCPU-1:0] to_cnt
);
   // one-cycle switch requests, valid in the cycle of the write
   always_comb begin
      to_user = '0;
      to_cnt  = '0;
      if (wr_en) begin
         to_user = wdata & ~mode_q;
         to_cnt  = ~wdata & mode_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mode_q <= '0;
      else if (wr_en) mode_q <= wdata;
   end
endmodule

// File: rtl/pcnt_channel.sv
module pcnt_channel
   import pcnt_pkg::*;
#(
   parameter int unsigned FRAC      = 9,
   parameter bit          SHADOW_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        user_mode,
   input  logic        to_user,
   input  logic        to_cnt,
   input  logic        wr_en,
   input  logic        rd_en,
   input  pcnt_off_e   off,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        irq,
   output logic        running
);
   localparam int unsigned USER_W = FULL_W - FRAC;   // count units in user mode
   localparam int unsigned CNT_W  = 31 - FRAC;       // count units in counter mode
   localparam int unsigned LO_W   = WORD_W - FRAC;   // units held by the low word

   logic [USER_W-1:0] cnt;
   logic [CNT_W-1:0]  lim;
   logic              reached;
   logic              irq_q;
   logic              run_q;
   logic [31:0]       hi_live;
   logic [31:0]       hi_word;
   logic              switching;

   assign switching = to_user | to_cnt;
   assign hi_live   = {reached, cnt[USER_W-1:LO_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         lim     <= '0;
         reached <= 1'b0;
         irq_q   <= 1'b0;
         run_q   <= 1'b0;
      end else if (switching) begin
         // stop, clear, restart in the new personality
         cnt     <= '0;
         reached <= 1'b0;
         irq_q   <= 1'b0;
         run_q   <= 1'b0;
         if (to_cnt) lim <= '0;
      end else if (wr_en) begin
         if (user_mode) begin
            case (off)
               OFF_HI: begin
                  cnt[USER_W-1:LO_W] <= wdata[30:0];
                  reached            <= 1'b0;
               end
               OFF_LO: begin
                  cnt[LO_W-1:0] <= wdata[31:FRAC];
                  reached       <= 1'b0;
               end
               OFF_RUN: run_q <= wdata[0];
               default: ;
            endcase
         end else if (off == OFF_HI) begin
            lim     <= wdata[30:FRAC];
            cnt     <= '0;
            reached <= 1'b0;
            irq_q   <= 1'b0;
         end
      end else begin
         if (rd_en && !user_mode && off == OFF_HI) begin
            reached <= 1'b0;
            irq_q   <= 1'b0;
         end
         // a tick in the same cycle takes precedence over the acknowledge
         if (tick) begin
            if (user_mode) begin
               if (run_q) begin
                  cnt <= cnt + 1'b1;
                  if (&cnt) reached <= 1'b1;
               end
            end else if (lim != '0 && cnt[CNT_W-1:0] == lim - 1'b1) begin
               cnt     <= '0;
               reached <= 1'b1;
               irq_q   <= 1'b1;
            end else if (&cnt[CNT_W-1:0]) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   generate
      if (SHADOW_EN) begin : g_shadow
         logic [31:0] sh_q;
         logic        shv_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q  <= '0;
               shv_q <= 1'b0;
            end else if (switching) begin
               shv_q <= 1'b0;
            end else if (rd_en && user_mode && off == OFF_LO) begin
               sh_q  <= hi_live;
               shv_q <= 1'b1;
            end else if (rd_en && user_mode && off == OFF_HI) begin
               shv_q <= 1'b0;
            end
         end
         assign hi_word = shv_q ? sh_q : hi_live;
      end else begin : g_live
         assign hi_word = hi_live;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      case (off)
         OFF_HI:  rdata = user_mode ? hi_word : {1'b0, lim, {FRAC{1'b0}}};
         OFF_LO:  rdata = user_mode ? {cnt[LO_W-1:0], {FRAC{1'b0}}}
                                    : {reached, cnt[CNT_W-1:0], {FRAC{1'b0}}};
         OFF_RUN: rdata = {31'b0, running};
         default: rdata = '0;
      endcase
   end

   assign running = user_mode ? run_q : 1'b1;
   assign irq     = irq_q;
endmodule

// File: rtl/pcnt_array.sv
module pcnt_array
   import pcnt_pkg::*;
#(
   parameter int unsigned NCPU      = 2,
   parameter int unsigned FRAC      = 9,
   parameter bit          SHADOW_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic [2:0]      bus_chan,
   input  logic [2:0]      bus_word,
   input  logic            bus_wr,
   input  logic            bus_rd,
   input  logic [31:0]     bus_wdata,
   output logic [31:0]     bus_rdata,
   output logic [NCPU-1:0] irq
);
   localparam int unsigned SLOTS = NCPU + 1;

   generate
      if (NCPU < 1 || NCPU > 4) begin : g_bad_ncpu
         $error("pcnt_array: NCPU must lie in 1..4");
      end
      if (FRAC < 1 || FRAC > 20) begin : g_bad_frac
         $error("pcnt_array: FRAC must lie in 1..20");
      end
      if (SLOTS > 8) begin : g_bad_slots
         $error("pcnt_array: slot select is three bits wide");
      end
   endgenerate

   pcnt_off_e       off;
   logic            mode_wr;
   logic [NCPU-1:0] mode_q;
   logic [NCPU-1:0] to_user;
   logic [NCPU-1:0] to_cnt;
   logic [NCPU-1:0] run_vec;
   logic [31:0]     ch_rdata [NCPU];

   assign off     = pcnt_off_e'(bus_word);
   assign mode_wr = bus_wr && bus_chan == 3'd0 && off == OFF_MODE;

   pcnt_modereg #(.NCPU(NCPU)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mode_wr),
      .wdata   (bus_wdata[NCPU-1:0]),
      .mode_q  (mode_q),
      .to_user (to_user),
      .to_cnt  (to_cnt)
   );

   generate
      for (genvar i = 0; i < NCPU; i++) begin : g_ch
         logic sel;
         assign sel = (bus_chan == 3'(i + 1));
         pcnt_channel #(.FRAC(FRAC), .SHADOW_EN(SHADOW_EN)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .user_mode (mode_q[i]),
            .to_user   (to_user[i]),
            .to_cnt    (to_cnt[i]),
            .wr_en     (bus_wr & sel),
            .rd_en     (bus_rd & sel),
            .off       (off),
            .wdata     (bus_wdata),
            .rdata     (ch_rdata[i]),
            .irq       (irq[i]),
            .running   (run_vec[i])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_chan == 3'd0) begin
         if (off == OFF_MODE) bus_rdata[NCPU-1:0] = mode_q;
      end else begin
         for (int i = 0; i < NCPU; i++) begin
            if (bus_chan == 3'(i + 1)) bus_rdata = ch_rdata[i];
         end
      end
   end
endmodule

// File: rtl/pcnt_array_chk.sv
module pcnt_array_chk #(
   parameter int unsigned NCPU = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tick,
   input logic [2:0]      bus_chan,
   input logic [2:0]      bus_word,
   input logic            bus_wr,
   input logic [31:0]     bus_wdata,
   input logic [NCPU-1:0] irq,
   input logic [NCPU-1:0] mode_q,
   input logic [NCPU-1:0] run_vec
);
   // R2: mode register takes the written low bits
   a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_chan == 3'd0 && bus_word == 3'd4)
      |=> mode_q == $past(bus_wdata[NCPU-1:0]));

   generate
      for (genvar i = 0; i < NCPU; i++) begin : g_c
         // R11: user-mode channel is silent
         a_r11_user_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            mode_q[i] |-> !irq[i]);
         // R4: interrupt only rises after a tick in counter mode
         a_r4_irq_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> ($past(tick) && !mode_q[i]));
         // R6: entering user mode leaves the timer stopped
         a_r6_enter_stopped: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mode_q[i]) |-> !run_vec[i]);
         // R3: limit write in counter mode drops the interrupt
         a_r3_limit_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_chan == 3'(i + 1) && bus_word == 3'd0 && !mode_q[i])
            |=> !irq[i]);
      end
   endgenerate
endmodule

bind pcnt_array pcnt_array_chk #(.NCPU(NCPU)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .bus_chan  (bus_chan),
   .bus_word  (bus_word),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .mode_q    (mode_q),
   .run_vec   (run_vec)
);

// File: tb/sim_pcnt_array.sv
`timescale 1ns/1ps
module sim_pcnt_array;
   localparam int NCPU = 2;
   localparam longint unsigned UMAX = 64'h003F_FFFF_FFFF_FFFF;
   localparam int unsigned CMAX = 32'h003F_FFFF;
   localparam longint unsigned LOMASK = 64'h7F_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [2:0]  bus_chan = '0;
   logic [2:0]  bus_word = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCPU-1:0] irq;

   always #2.5 clk = ~clk;

   pcnt_array #(.NCPU(NCPU)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_chan(bus_chan),
      .bus_word(bus_word), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model
   bit              m_mode  [NCPU];
   longint unsigned m_cnt   [NCPU];
   int unsigned     m_lim   [NCPU];
   bit              m_reach [NCPU];
   bit              m_irq   [NCPU];
   bit              m_run   [NCPU];
   bit              m_shv   [NCPU];
   logic [31:0]     m_sh    [NCPU];

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] hi_live(int i);
      return {m_reach[i], m_cnt[i][53:23]};
   endfunction

   function automatic logic [31:0] exp_read(int ch, int off);
      int i;
      if (ch == 0) return (off == 4) ? 32'(m_mode[0]) | (32'(m_mode[1]) << 1) : 32'h0;
      i = ch - 1;
      if (m_mode[i]) begin
         case (off)
            0: return m_shv[i] ? m_sh[i] : hi_live(i);
            1: return {m_cnt[i][22:0], 9'b0};
            3: return 32'(m_run[i]);
            default: return 32'h0;
         endcase
      end
      case (off)
         0: return m_lim[i] << 9;
         1: return (32'(m_reach[i]) << 31) | (m_cnt[i][31:0] << 9);
         3: return 32'h1;
         default: return 32'h0;
      endcase
   endfunction

   task automatic idle();
      tick = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic bus_write(int ch, int off, logic [31:0] d);
      int i;
      @(negedge clk);
      idle();
      bus_chan = 3'(ch); bus_word = 3'(off); bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      if (ch == 0 && off == 4) begin
         for (int k = 0; k < NCPU; k++) begin
            if (d[k] != m_mode[k]) begin
               m_cnt[k] = 0; m_reach[k] = 0; m_irq[k] = 0; m_run[k] = 0; m_shv[k] = 0;
               if (!d[k]) m_lim[k] = 0;
            end
            m_mode[k] = d[k];
         end
      end else if (ch >= 1 && ch <= NCPU) begin
         i = ch - 1;
         if (m_mode[i]) begin
            if (off == 0) begin
               m_cnt[i] = (m_cnt[i] & LOMASK) | (longint'(d[30:0]) << 23); m_reach[i] = 0;
            end else if (off == 1) begin
               m_cnt[i] = (m_cnt[i] & ~LOMASK) | longint'(d[31:9]); m_reach[i] = 0;
            end else if (off == 3) m_run[i] = d[0];
         end else if (off == 0) begin
            m_lim[i] = d[30:9]; m_cnt[i] = 0; m_reach[i] = 0; m_irq[i] = 0;
         end
      end
   endtask

   task automatic bus_read(int ch, int off, string req);
      int i;
      @(negedge clk);
      idle();
      bus_chan = 3'(ch); bus_word = 3'(off); bus_rd = 1'b1;
      #1 check(req, bus_rdata, exp_read(ch, off));
      @(posedge clk);
      if (ch >= 1 && ch <= NCPU) begin
         i = ch - 1;
         if (m_mode[i]) begin
            if (off == 1) begin m_sh[i] = hi_live(i); m_shv[i] = 1; end
            else if (off == 0) m_shv[i] = 0;
         end else if (off == 0) begin
            m_reach[i] = 0; m_irq[i] = 0;
         end
      end
   endtask

   task automatic tick_n(int n);
      for (int t = 0; t < n; t++) begin
         @(negedge clk);
         idle();
         tick = 1'b1;
         @(posedge clk);
         for (int k = 0; k < NCPU; k++) begin
            if (m_mode[k]) begin
               if (m_run[k]) begin
                  if (m_cnt[k] == UMAX) begin m_cnt[k] = 0; m_reach[k] = 1; end
                  else m_cnt[k]++;
               end
            end else if (m_lim[k] != 0 && m_cnt[k] == longint'(m_lim[k] - 1)) begin
               m_cnt[k] = 0; m_reach[k] = 1; m_irq[k] = 1;
            end else if (m_cnt[k] == longint'(CMAX)) m_cnt[k] = 0;
            else m_cnt[k]++;
         end
      end
   endtask

   task automatic chk_irq(string req);
      @(negedge clk);
      idle();
      #1 check(req, 32'(irq), 32'(m_irq[0]) | (32'(m_irq[1]) << 1));
   endtask

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int r, ch, off;
      logic [31:0] d;
      void'($urandom(32'h5EED_1234));
      for (int k = 0; k < NCPU; k++) begin
         m_mode[k] = 0; m_cnt[k] = 0; m_lim[k] = 0; m_reach[k] = 0;
         m_irq[k] = 0; m_run[k] = 0; m_shv[k] = 0; m_sh[k] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      bus_read(1, 3, "R1");
      bus_read(1, 1, "R1");
      bus_read(0, 4, "R1");
      chk_irq("R1");
      // R3, R4 limit match
      bus_write(1, 0, 32'h0000_0A00);
      tick_n(4);
      bus_read(1, 1, "R4");
      check("R4", exp_read(1, 1), 32'h0000_0800);
      tick_n(1);
      chk_irq("R4");
      check("R4", 32'(irq[0]), 32'h1);
      bus_read(1, 1, "R4");
      bus_read(1, 0, "R3");
      chk_irq("R3");
      check("R3", 32'(irq[0]), 32'h0);
      // R5 ignored writes in counter mode
      tick_n(2);
      bus_write(1, 1, 32'hFFFF_FFFF);
      bus_read(1, 1, "R5");
      bus_write(1, 3, 32'h0);
      bus_read(1, 3, "R5");
      // R2 mode write with junk high bits, R6 entry state
      bus_write(0, 4, 32'hFFFF_FFFD);
      bus_read(0, 4, "R2");
      check("R2", exp_read(0, 4), 32'h1);
      bus_read(1, 3, "R6");
      bus_read(1, 1, "R6");
      chk_irq("R6");
      // R10 start/stop
      tick_n(3);
      bus_read(1, 1, "R10");
      bus_write(1, 3, 32'h1);
      tick_n(3);
      bus_read(1, 1, "R10");
      check("R10", exp_read(1, 1), 32'h0000_0600);
      bus_write(1, 3, 32'h0);
      tick_n(2);
      bus_read(1, 1, "R10");
      // R9, R8 loads and readback
      bus_write(1, 0, 32'hFFFF_FFFF);
      bus_write(1, 1, 32'hFFFF_FFFF);
      bus_read(1, 1, "R9");
      bus_read(1, 0, "R8");
      check("R8", exp_read(1, 0), 32'h7FFF_FFFF);
      // R11 wrap at all-ones, no interrupt
      bus_write(1, 3, 32'h1);
      tick_n(1);
      chk_irq("R11");
      bus_read(1, 1, "R11");
      bus_read(1, 0, "R11");
      check("R11", exp_read(1, 0), 32'h8000_0000);
      // R12 shadow across carry
      bus_write(1, 0, 32'h0000_0010);
      bus_write(1, 1, 32'hFFFF_FE00);
      bus_read(1, 1, "R12");
      tick_n(1);
      bus_read(1, 0, "R12");
      check("R12", m_sh[0], 32'h0000_0010);
      bus_read(1, 0, "R12");
      check("R12", exp_read(1, 0), 32'h0000_0011);
      // R7 back to counter mode
      bus_write(0, 4, 32'h0);
      bus_read(1, 3, "R7");
      bus_read(1, 0, "R7");
      tick_n(2);
      bus_read(1, 1, "R7");

      // random phase
      for (int n = 0; n < 600; n++) begin
         r = $urandom % 10;
         ch = 1 + ($urandom % NCPU);
         if (r == 0) begin
            bus_write(0, 4, $urandom);
         end else if (r <= 2) begin
            case ($urandom % 3)
               0: off = 0;
               1: off = 1;
               default: off = 3;
            endcase
            d = $urandom;
            if (off == 0 && !m_mode[ch-1]) d = (d & 32'h8000_01FF) | (($urandom % 8) << 9);
            else if (off == 0 && ($urandom % 2) == 1) d = 32'h7FFF_FFFF;
            else if (off == 1 && ($urandom % 2) == 1) d = 32'hFFFF_FE00;
            bus_write(ch, off, d);
         end else if (r <= 5) begin
            ch = $urandom % (NCPU + 1);
            off = $urandom % 5;
            bus_read(ch, off, (ch != 0 && m_mode[ch-1]) ? "R8" : "R4");
         end else begin
            tick_n(1 + ($urandom % 4));
            chk_irq("R11");
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule